// File: doc/BRIEF.md
# Multi-mode host bus interface

This block is the host-facing front end of a small display controller. A microcontroller delivers bytes over one of five bus protocols: two parallel styles (a write-strobe/read-strobe style and a read-write/enable style), SPI with a separate data/command pin, SPI with the data/command flag carried as a ninth bit, and a write-only I2C target. Three static mode pins choose the protocol. The pins are shared: in the serial modes, data bit 0 is the serial clock and data bit 1 is the serial data line. In I2C the data/command pin becomes the least significant bit of the target address, so two controllers can sit on one bus.

Every external pin first passes through a two-flop synchronizer on the system clock, and all edges are found on the synchronized copies. Each accepted byte leaves the block as a stream beat: `out_valid` is high for exactly one cycle, with `out_data` and `out_dc`. There is no ready input, because the host bus cannot be stalled. The consumer must take every beat, and beats are always many cycles apart.

In the parallel modes the block drives read-back data from `rd_data_i` onto the bus through `db_o`/`db_oe`. In I2C it uses the same pins to pull the data line low for the acknowledge. In parallel writes, data and the data/command pin must stay stable for at least three system clocks after the end of the strobe.

Top module: `hbi_host_if`

## Requirements
- R1: A mode code on `mode_i` (bit 0, bit 1, bit 2) other than the five listed here produces no beat and never drives the bus. The five codes are 3'b110 strobe-parallel, 3'b100 enable-parallel, 3'b000 SPI with a data/command pin, 3'b001 nine-bit SPI, and 3'b010 I2C.
- R2: While `csn_i` is high, no beat is produced and `db_oe` is all zero.
- R3: In strobe-parallel mode, a rising edge of `wr_i` captures `db_i` as one beat, with `out_dc` equal to `dc_i` (1 = display data, 0 = command).
- R4: In strobe-parallel mode, while `rd_i` is low with chip select active, `db_oe` is 8'hFF and `db_o` equals `rd_data_i`. Otherwise the bus is released.
- R5: In enable-parallel mode, `wr_i` is read/write (1 = read) and `rd_i` is an active-high enable. A falling enable with read/write low captures a beat, and the bus is driven while the enable and read/write are both high.
- R6: In SPI with a data/command pin, 8 bits are shifted MSB first on rising serial clock edges, and `dc_i` is sampled with the eighth bit.
- R7: In nine-bit SPI, the first bit of each group of nine is the data/command flag and the next 8 bits are the byte, MSB first. `dc_i` is ignored.
- R8: The SPI bit counter clears whenever chip select goes inactive, so a partial byte is discarded.
- R9: In I2C, only a write to address {I2C_ADDR_HI, dc_i} is acknowledged. With I2C_ADDR_HI = 6'b011110, the address bytes are 8'h78 (dc_i = 0) and 8'h7A (dc_i = 1). Any other address produces no acknowledge and no beat until the next start.
- R10: In I2C, after the address, a control byte comes first. Its bit 7 is a continuation flag and its bit 6 is the data/command flag. With continuation set, exactly one data byte follows and then another control byte. With continuation clear, every byte up to the stop is data.
- R11: In I2C, the address, control and data bytes are acknowledged by pulling data bit 1 low (`db_oe[1]`=1, `db_o[1]`=0) from the falling clock edge after the eighth bit until the falling edge after the ninth. Every I2C data beat coincides with the acknowledge.
- R12: Each accepted byte gives exactly one beat, one cycle wide.
- R13: In the serial and I2C modes, `db_oe[7:2]` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 3 | Static protocol select |
| csn_i | input | 1 | Chip select, active low |
| dc_i | input | 1 | Data/command; I2C address bit 0 |
| wr_i | input | 1 | Write strobe (active low) or read/write |
| rd_i | input | 1 | Read strobe (active low) or enable |
| db_i | input | 8 | Data bus in; bit 0 serial clock, bit 1 serial data |
| db_o | output | 8 | Data bus out value |
| db_oe | output | 8 | Per-bit drive enable for the data bus |
| rd_data_i | input | 8 | Read-back value for parallel reads |
| out_valid | output | 1 | One-cycle byte beat |
| out_dc | output | 1 | Beat flag: 1 data, 0 command |
| out_data | output | 8 | Beat byte |

## Verification
In I2C the byte beat and the acknowledge drive both start from the falling clock after the eighth data bit, so they overlap. The bench provokes this with a wired-AND model of the data line, so the host sees the acknowledge that the block drives. At the ninth clock the bench samples the acknowledge, and a scoreboard checks the beat. A checker confirms that every I2C beat sees the data line held low. A second overlap is a parallel read drive followed by a write in the same chip-select window; the bench checks that one does not disturb the other.

// File: rtl/hbi_pkg.sv
package hbi_pkg;
  localparam int DW = 8;

  localparam logic [2:0] M_STRB = 3'b110;
  localparam logic [2:0] M_ENBL = 3'b100;
  localparam logic [2:0] M_SPI4 = 3'b000;
  localparam logic [2:0] M_SPI3 = 3'b001;
  localparam logic [2:0] M_I2C  = 3'b010;

  typedef struct packed {
    logic          v;
    logic          dc;
    logic [DW-1:0] d;
  } hbi_byte_t;

  typedef enum logic [2:0] {I_IDLE, I_ADDR, I_CTRL, I_ONE, I_RUN} i2c_st_t;
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '1;
      q_o  <= '1;
    end else begin
      meta <= a_i;
      q_o  <= meta;
    end
  end
endmodule

// File: rtl/hbi_par.sv
module hbi_par import hbi_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          is_enbl,
  input  logic          wr_s,
  input  logic          wr_p,
  input  logic          rd_s,
  input  logic          rd_p,
  input  logic          dc_s,
  input  logic [DW-1:0] db_s,
  output hbi_byte_t     byte_o,
  output logic          drive_o
);
  logic take;

  // enable-parallel: falling enable with rw low; strobe-parallel: rising write strobe
  assign take    = en & (is_enbl ? (rd_p & ~rd_s & ~wr_s) : (wr_s & ~wr_p));
  assign drive_o = en & (is_enbl ? (rd_s & wr_s) : ~rd_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
    end else begin
      byte_o.v <= take;
      if (take) begin
        byte_o.dc <= dc_s;
        byte_o.d  <= db_s;
      end
    end
  end
endmodule

// File: rtl/hbi_spi.sv
module hbi_spi import hbi_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      nine,
  input  logic      scl_s,
  input  logic      scl_p,
  input  logic      sda_s,
  input  logic      dc_s,
  output hbi_byte_t byte_o
);
  localparam int CW = $clog2(DW + 2);

  logic [CW-1:0] cnt;
  logic [DW-2:0] sh;
  logic          dcb;
  logic          rise, last;

  assign rise = en & scl_s & ~scl_p;
  assign last = nine ? (cnt == CW'(DW)) : (cnt == CW'(DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_o <= '0;
      cnt    <= '0;
      sh     <= '0;
      dcb    <= 1'b0;
    end else begin
      byte_o.v <= 1'b0;
      if (!en) begin
        cnt <= '0;
      end else if (rise) begin
        if (nine && cnt == '0) begin
          dcb <= sda_s;
          cnt <= CW'(1);
        end else if (last) begin
          byte_o.v  <= 1'b1;
          byte_o.dc <= nine ? dcb : dc_s;
          byte_o.d  <= {sh, sda_s};
          cnt       <= '0;
        end else begin
          sh  <= {sh[DW-3:0], sda_s};
          cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/hbi_i2c.sv
module hbi_i2c import hbi_pkg::*; #(
  parameter logic [5:0] ADDR_HI = 6'b011110
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      scl_s,
  input  logic      scl_p,
  input  logic      sda_s,
  input  logic      sda_p,
  input  logic      sel_s,
  output hbi_byte_t byte_o,
  output logic      ack_o
);
  localparam int CW = $clog2(DW + 1);

  i2c_st_t       st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          in_ack, dcr;
  logic          rise, fall, start, stop;

  assign rise  = scl_s & ~scl_p;
  assign fall  = ~scl_s & scl_p;
  assign start = scl_s & scl_p & sda_p & ~sda_s;
  assign stop  = scl_s & scl_p & ~sda_p & sda_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= I_IDLE;
      cnt    <= '0;
      sh     <= '0;
      in_ack <= 1'b0;
      ack_o  <= 1'b0;
      dcr    <= 1'b0;
      byte_o <= '0;
    end else begin
      byte_o.v <= 1'b0;
      if (!en) begin
        st     <= I_IDLE;
        ack_o  <= 1'b0;
        in_ack <= 1'b0;
        cnt    <= '0;
      end else if (start) begin
        st     <= I_ADDR;
        cnt    <= '0;
        in_ack <= 1'b0;
        ack_o  <= 1'b0;
      end else if (stop) begin
        st     <= I_IDLE;
        in_ack <= 1'b0;
        ack_o  <= 1'b0;
      end else if (st != I_IDLE) begin
        if (rise && !in_ack && cnt < CW'(DW)) begin
          sh  <= {sh[DW-2:0], sda_s};
          cnt <= cnt + CW'(1);
        end else if (fall && in_ack) begin
          in_ack <= 1'b0;
          ack_o  <= 1'b0;
          cnt    <= '0;
        end else if (fall && cnt == CW'(DW)) begin
          in_ack <= 1'b1;
          ack_o  <= 1'b1;
          case (st)
            I_ADDR: begin
              if (sh[7:1] == {ADDR_HI, sel_s} && !sh[0]) st <= I_CTRL;
              else begin
                st    <= I_IDLE;
                ack_o <= 1'b0;
              end
            end
            I_CTRL: begin
              dcr <= sh[6];
              st  <= sh[7] ? I_ONE : I_RUN;
            end
            I_ONE: begin
              byte_o.v  <= 1'b1;
              byte_o.dc <= dcr;
              byte_o.d  <= sh;
              st        <= I_CTRL;
            end
            I_RUN: begin
              byte_o.v  <= 1'b1;
              byte_o.dc <= dcr;
              byte_o.d  <= sh;
            end
            default: st <= I_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/hbi_host_if.sv
module hbi_host_if import hbi_pkg::*; #(
  parameter logic [5:0] I2C_ADDR_HI = 6'b011110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    mode_i,
  input  logic          csn_i,
  input  logic          dc_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] db_i,
  output logic [DW-1:0] db_o,
  output logic [DW-1:0] db_oe,
  input  logic [DW-1:0] rd_data_i,
  output logic          out_valid,
  output logic          out_dc,
  output logic [DW-1:0] out_data
);
  localparam int SW = DW + 4;

  logic [SW-1:0] s;
  logic [3:0]    e_p;
  logic          cs_act, dc_s, wr_s, rd_s;
  logic [DW-1:0] db_s;
  logic          is_strb, is_enbl, is_spi4, is_spi3, is_i2c;
  logic          par_drive, i2c_ack;
  hbi_byte_t     par_b, spi_b, i2c_b, pick, out_q;

  hbi_sync #(.W(SW)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   ({db_i, rd_i, wr_i, dc_i, csn_i}),
    .q_o   (s)
  );

  assign cs_act = ~s[0];
  assign dc_s   = s[1];
  assign wr_s   = s[2];
  assign rd_s   = s[3];
  assign db_s   = s[SW-1:4];

  // previous synchronized level of the edge-detected pins: {sda, scl, rd, wr}
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) e_p <= '1;
    else        e_p <= {db_s[1], db_s[0], rd_s, wr_s};
  end

  assign is_strb = (mode_i == M_STRB);
  assign is_enbl = (mode_i == M_ENBL);
  assign is_spi4 = (mode_i == M_SPI4);
  assign is_spi3 = (mode_i == M_SPI3);
  assign is_i2c  = (mode_i == M_I2C);

  hbi_par u_par (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cs_act & (is_strb | is_enbl)),
    .is_enbl (is_enbl),
    .wr_s    (wr_s),
    .wr_p    (e_p[0]),
    .rd_s    (rd_s),
    .rd_p    (e_p[1]),
    .dc_s    (dc_s),
    .db_s    (db_s),
    .byte_o  (par_b),
    .drive_o (par_drive)
  );

  hbi_spi u_spi (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cs_act & (is_spi4 | is_spi3)),
    .nine   (is_spi3),
    .scl_s  (db_s[0]),
    .scl_p  (e_p[2]),
    .sda_s  (db_s[1]),
    .dc_s   (dc_s),
    .byte_o (spi_b)
  );

  hbi_i2c #(.ADDR_HI(I2C_ADDR_HI)) u_i2c (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cs_act & is_i2c),
    .scl_s  (db_s[0]),
    .scl_p  (e_p[2]),
    .sda_s  (db_s[1]),
    .sda_p  (e_p[3]),
    .sel_s  (dc_s),
    .byte_o (i2c_b),
    .ack_o  (i2c_ack)
  );

  always_comb begin
    pick = '0;
    if (par_b.v)      pick = par_b;
    else if (spi_b.v) pick = spi_b;
    else if (i2c_b.v) pick = i2c_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= pick;
  end

  assign out_valid = out_q.v;
  assign out_dc    = out_q.dc;
  assign out_data  = out_q.d;

  assign db_oe = par_drive ? '1 : {{(DW-2){1'b0}}, i2c_ack, 1'b0};
  assign db_o  = par_drive ? rd_data_i : '0;
endmodule

// File: rtl/hbi_host_if_chk.sv
module hbi_host_if_chk import hbi_pkg::*; (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    mode_i,
  input logic          csn_i,
  input logic          sda_o,
  input logic [DW-1:0] db_oe,
  input logic          out_valid
);
  logic [2:0] cs_hi_cnt;
  logic       known, serial;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cs_hi_cnt <= '0;
    else if (!csn_i)                  cs_hi_cnt <= '0;
    else if (cs_hi_cnt != 3'd7)       cs_hi_cnt <= cs_hi_cnt + 3'd1;
  end

  assign known  = (mode_i == M_STRB) || (mode_i == M_ENBL) || (mode_i == M_SPI4) ||
                  (mode_i == M_SPI3) || (mode_i == M_I2C);
  assign serial = (mode_i == M_SPI4) || (mode_i == M_SPI3) || (mode_i == M_I2C);

  a_r1_no_mode_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !known |-> (db_oe == '0 && !out_valid));

  a_r2_cs_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_hi_cnt >= 3'd5) |-> (db_oe == '0 && !out_valid));

  a_r11_ack_with_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == M_I2C && out_valid) |-> (db_oe[1] && !sda_o));

  a_r12_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  a_r13_serial_upper_hiz: assert property (@(posedge clk) disable iff (!rst_n)
    serial |-> (db_oe[DW-1:2] == '0));
endmodule

bind hbi_host_if hbi_host_if_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_i    (mode_i),
  .csn_i     (csn_i),
  .sda_o     (db_o[1]),
  .db_oe     (db_oe),
  .out_valid (out_valid)
);

// File: tb/test_hbi_host_if.sv
`timescale 1ns/1ps
module test_hbi_host_if;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n, csn, dc, wr, rd, sda_drv, i2c_on, timed_out;
  logic [2:0] mode;
  logic [7:0] db_drv, rd_data, db_in, db_o, db_oe, out_data;
  logic       out_valid, out_dc;
  int         n_cmp = 0, n_bad = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [8:0] e_item;
  string      e_tag;

  assign db_in = i2c_on ? {db_drv[7:2], sda_drv & ~(db_oe[1] & ~db_o[1]), db_drv[0]} : db_drv;

  hbi_host_if i_hbi_host_if (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .csn_i(csn), .dc_i(dc), .wr_i(wr), .rd_i(rd),
    .db_i(db_in), .db_o(db_o), .db_oe(db_oe), .rd_data_i(rd_data),
    .out_valid(out_valid), .out_dc(out_dc), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_beat(input logic d_c, input logic [7:0] d, input string tag);
    exp_q.push_back({d_c, d});
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected beat for each observed beat
  always @(negedge clk) begin
    if (rst_n === 1'b1 && out_valid === 1'b1) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 beat with nothing expected", {23'd0, out_dc, out_data}, 32'd0);
      end else begin
        e_item = exp_q.pop_front();
        e_tag  = tag_q.pop_front();
        check({out_dc, out_data} == e_item, e_tag, {23'd0, out_dc, out_data}, {23'd0, e_item});
      end
    end
  end

  task automatic drain(input string tag);
    tick(8);
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  task automatic do_reset(input logic [2:0] m);
    rst_n = 1'b0; mode = m; csn = 1'b1; dc = 1'b0; wr = 1'b1; rd = 1'b1;
    db_drv = 8'h00; sda_drv = 1'b1; i2c_on = (m == 3'b010); rd_data = 8'h00;
    if (m == 3'b100) begin rd = 1'b0; wr = 1'b0; end
    if (m == 3'b010) db_drv[0] = 1'b1;
    tick(4);
    rst_n = 1'b1;
    tick(4);
  endtask

  task automatic strb_write(input logic d_c, input logic [7:0] d);
    dc = d_c; db_drv = d; tick(2);
    wr = 1'b0; tick(4);
    wr = 1'b1; tick(5);
  endtask

  task automatic enbl_write(input logic d_c, input logic [7:0] d);
    wr = 1'b0; dc = d_c; db_drv = d; tick(2);
    rd = 1'b1; tick(4);
    rd = 1'b0; tick(5);
  endtask

  task automatic spi_bit(input logic b);
    db_drv[1] = b; tick(2);
    db_drv[0] = 1'b1; tick(3);
    db_drv[0] = 1'b0; tick(2);
  endtask

  task automatic spi4_byte(input logic d_c, input logic [7:0] d);
    dc = d_c;
    for (int i = 7; i >= 0; i--) spi_bit(d[i]);
    tick(5);
  endtask

  task automatic spi3_byte(input logic d_c, input logic [7:0] d);
    dc = ~d_c;
    spi_bit(d_c);
    for (int i = 7; i >= 0; i--) spi_bit(d[i]);
    tick(5);
  endtask

  task automatic i2c_start();
    sda_drv = 1'b1; db_drv[0] = 1'b1; tick(4);
    sda_drv = 1'b0; tick(4);
    db_drv[0] = 1'b0; tick(4);
  endtask

  task automatic i2c_stop();
    sda_drv = 1'b0; tick(3);
    db_drv[0] = 1'b1; tick(4);
    sda_drv = 1'b1; tick(4);
  endtask

  task automatic i2c_byte(input logic [7:0] b, output logic ack, output logic [7:0] oe_seen);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(3);
      db_drv[0] = 1'b1; tick(4);
      db_drv[0] = 1'b0; tick(3);
    end
    sda_drv = 1'b1; tick(4);
    db_drv[0] = 1'b1; tick(2);
    ack = db_oe[1] && !db_o[1];
    oe_seen = db_oe;
    tick(2);
    db_drv[0] = 1'b0; tick(5);
  endtask

  task automatic run_all();
    logic       ack;
    logic [7:0] oe;

    // reset state
    do_reset(3'b110);
    check(out_valid == 1'b0 && db_oe == 8'h00, "R2 reset state quiet", {23'd0, out_valid, db_oe}, 0);

    // unsupported mode
    do_reset(3'b111);
    csn = 1'b0; tick(4);
    strb_write(1'b1, 8'hE7);
    rd = 1'b0; tick(5);
    check(db_oe == 8'h00, "R1 unknown mode never drives", db_oe, 0);
    rd = 1'b1; tick(2);
    drain("R1 unknown mode gives no beat");

    // strobe-parallel
    do_reset(3'b110);
    csn = 1'b0; tick(4);
    expect_beat(1'b1, 8'hA5, "R3 strobe write data");
    strb_write(1'b1, 8'hA5);
    expect_beat(1'b0, 8'h3C, "R3 strobe write command");
    strb_write(1'b0, 8'h3C);
    rd_data = 8'h5C; rd = 1'b0; tick(5);
    check(db_oe == 8'hFF && db_o == 8'h5C, "R4 read drives bus", {db_oe, db_o}, 16'hFF5C);
    rd = 1'b1; tick(5);
    check(db_oe == 8'h00, "R4 read released", db_oe, 0);
    expect_beat(1'b1, 8'h0F, "R4 write after read");
    strb_write(1'b1, 8'h0F);
    drain("R3 strobe beats all seen");
    csn = 1'b1; tick(5);
    strb_write(1'b1, 8'h99);
    rd = 1'b0; tick(5);
    check(db_oe == 8'h00, "R2 chip select high blocks read", db_oe, 0);
    rd = 1'b1; tick(2);
    drain("R2 chip select high blocks write");

    // enable-parallel
    do_reset(3'b100);
    csn = 1'b0; tick(4);
    expect_beat(1'b1, 8'h5A, "R5 enable write data");
    enbl_write(1'b1, 8'h5A);
    expect_beat(1'b0, 8'hC3, "R5 enable write command");
    enbl_write(1'b0, 8'hC3);
    rd_data = 8'h81; wr = 1'b1; tick(2);
    check(db_oe == 8'h00, "R5 no drive with enable low", db_oe, 0);
    rd = 1'b1; tick(5);
    check(db_oe == 8'hFF && db_o == 8'h81, "R5 enable read drives", {db_oe, db_o}, 16'hFF81);
    rd = 1'b0; tick(2); wr = 1'b0; tick(5);
    check(db_oe == 8'h00, "R5 enable read released", db_oe, 0);
    drain("R5 enable beats all seen");

    // SPI with data/command pin
    do_reset(3'b000);
    csn = 1'b0; tick(4);
    expect_beat(1'b1, 8'h81, "R6 spi4 data byte");
    spi4_byte(1'b1, 8'h81);
    expect_beat(1'b0, 8'h7E, "R6 spi4 command byte");
    spi4_byte(1'b0, 8'h7E);
    check(db_oe == 8'h00, "R13 spi leaves bus undriven", db_oe, 0);
    spi_bit(1'b1); spi_bit(1'b1); spi_bit(1'b1);
    csn = 1'b1; tick(5);
    csn = 1'b0; tick(4);
    expect_beat(1'b0, 8'h3C, "R8 partial byte discarded");
    spi4_byte(1'b0, 8'h3C);
    drain("R6 spi4 beats all seen");

    // nine-bit SPI
    do_reset(3'b001);
    csn = 1'b0; tick(4);
    expect_beat(1'b1, 8'h96, "R7 spi3 data byte");
    spi3_byte(1'b1, 8'h96);
    expect_beat(1'b0, 8'h01, "R7 spi3 command byte");
    spi3_byte(1'b0, 8'h01);
    drain("R7 spi3 beats all seen");

    // I2C
    do_reset(3'b010);
    csn = 1'b0; dc = 1'b0; tick(4);
    i2c_start();
    i2c_byte(8'h78, ack, oe);
    check(ack == 1'b1, "R11 address acknowledged", ack, 1);
    check(oe[7:2] == 6'd0, "R13 i2c upper bits undriven", oe, 8'h02);
    i2c_byte(8'hC0, ack, oe);
    check(ack == 1'b1, "R11 control acknowledged", ack, 1);
    expect_beat(1'b1, 8'hAB, "R10 one data byte after continuation");
    i2c_byte(8'hAB, ack, oe);
    check(ack == 1'b1, "R11 data acknowledged", ack, 1);
    i2c_byte(8'h00, ack, oe);
    check(ack == 1'b1, "R10 second control acknowledged", ack, 1);
    expect_beat(1'b0, 8'h11, "R10 stream byte one");
    i2c_byte(8'h11, ack, oe);
    expect_beat(1'b0, 8'h22, "R10 stream byte two");
    i2c_byte(8'h22, ack, oe);
    i2c_stop();
    drain("R10 i2c beats all seen");

    i2c_start();
    i2c_byte(8'h7A, ack, oe);
    check(ack == 1'b0, "R9 wrong address not acknowledged", ack, 0);
    i2c_byte(8'h40, ack, oe);
    i2c_byte(8'h55, ack, oe);
    check(ack == 1'b0, "R9 ignored after mismatch", ack, 0);
    i2c_stop();
    drain("R9 no beat after mismatch");

    dc = 1'b1; tick(4);
    i2c_start();
    i2c_byte(8'h7A, ack, oe);
    check(ack == 1'b1, "R9 select pin moves address", ack, 1);
    i2c_byte(8'h40, ack, oe);
    expect_beat(1'b1, 8'h99, "R10 data flag from control");
    i2c_byte(8'h99, ack, oe);
    i2c_stop();
    drain("R9 second address beats all seen");
  endtask

  initial begin
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule